// File: doc/BRIEF.md
# Reflected CRC-32 Stream Engine

This block computes a 32-bit cyclic redundancy check over a stream of bytes, one byte per clock. It uses the reflected, LSB-first form of the common 32-bit polynomial (constant 0xEDB88320). The running remainder starts at all ones, and the reported value is the remainder inverted. A message is framed by a start strobe on its first byte and an end strobe on its last byte. Both strobes are qualified by a valid input.

One clock after the final byte, the engine presents the finished CRC and raises a one-cycle done pulse. If check mode is enabled on that final beat, the engine also compares the finished CRC with an expected 32-bit value and flags pass or fail along with the pulse. The engine only detects corruption. It never tries to repair it.

Top module: `crc32_stream_engine`

## Requirements
- R1: During and after a synchronous active-high reset, `done`, `pass` and `fail` are 0 and `crc_out` is 0x00000000 until the first end-of-message beat.
- R2: The remainder is preset to 0xFFFFFFFF for each message. Each byte is XORed into bits [7:0] of the remainder, followed by eight right-shift steps that XOR in 0xEDB88320 whenever the bit shifted out is 1. The result is the remainder XOR 0xFFFFFFFF. The ASCII bytes "123456789" give 0xCBF43926.
- R3: A byte is absorbed on each clock where `in_valid` is 1. Cycles with `in_valid` at 0 leave the message state untouched, so gaps between bytes do not change the result.
- R4: A beat with `in_valid` and `in_sop` both 1 discards any partial message and restarts from the preset, with that beat's byte absorbed in the same cycle.
- R5: `done` is 1 for exactly the cycle after each beat with `in_valid` and `in_eop` both 1, and is 0 in every other cycle. Back-to-back end beats give back-to-back pulses.
- R6: `crc_out` takes the finished CRC in the same cycle `done` rises, and holds it until the next end-of-message beat.
- R7: When `chk_en` is 1 on the end beat, `pass` (if the finished CRC equals `chk_value`) or `fail` (if it does not) is 1 together with `done`. When `chk_en` is 0 on the end beat, both stay 0. `pass` and `fail` are never 1 outside a `done` cycle, and never both 1.
- R8: Any single flipped bit in a message checked against the uncorrupted message's CRC yields `fail`.
- R9: Any error burst of 32 bits or fewer in a message checked against the uncorrupted message's CRC yields `fail`.
- R10: A message of one byte, with `in_sop` and `in_eop` on the same beat, is valid. The single byte 0x00 gives 0xD202EF8D.
- R11: `in_sop` and `in_eop` have no effect on a cycle where `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is absorbed this cycle |
| in_sop | input | 1 | First byte of a message (qualified by `in_valid`) |
| in_eop | input | 1 | Last byte of a message (qualified by `in_valid`) |
| in_byte | input | 8 | Message byte |
| chk_en | input | 1 | Compare the finished CRC on this end beat |
| chk_value | input | 32 | Expected CRC for the comparison |
| crc_out | output | 32 | Finished CRC of the last completed message |
| done | output | 1 | One-cycle pulse after an end beat |
| pass | output | 1 | Check matched, with `done` |
| fail | output | 1 | Check mismatched, with `done` |

## Verification
The known nine-digit ASCII vector and a one-byte zero message pin down the preset, the bit order, the polynomial and the final inversion. Any slip in these gives a different word. The same message is sent both back to back and with gaps in which stray strobes are driven, which separates correct valid-qualification from logic that absorbs or restarts on idle cycles. A message abandoned by a fresh start shows whether the preset reload happens in the restart cycle. Every single-bit flip of a 16-byte message, and bursts of every length from 1 to 32 at several offsets, are checked against the clean CRC, which proves the detection guarantee rather than one lucky pattern.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_WIDTH  = 32;
  localparam int unsigned BYTE_WIDTH = 8;
  localparam logic [31:0] REFL_POLY  = 32'hEDB88320;
  localparam logic [31:0] ALL_ONES   = 32'hFFFFFFFF;

  typedef struct packed {
    logic done;
    logic pass;
    logic fail;
  } verdict_t;
endpackage

// File: rtl/crc32_bit_step.sv
// One reflected division step: shift right, fold the polynomial in on a 1.
module crc32_bit_step #(
  parameter int unsigned     W    = crc32_pkg::CRC_WIDTH,
  parameter logic [W-1:0]    POLY = crc32_pkg::REFL_POLY
) (
  input  logic [W-1:0] rem_in,
  output logic [W-1:0] rem_out
);
  always_comb begin
    rem_out = (rem_in >> 1) ^ (rem_in[0] ? POLY : '0);
  end
endmodule

// File: rtl/crc32_byte_unroll.sv
// Absorbs DW bits in one pass: data folded into the low bits, then DW steps.
module crc32_byte_unroll #(
  parameter int unsigned  W    = crc32_pkg::CRC_WIDTH,
  parameter int unsigned  DW   = crc32_pkg::BYTE_WIDTH,
  parameter logic [W-1:0] POLY = crc32_pkg::REFL_POLY
) (
  input  logic [W-1:0]  rem_in,
  input  logic [DW-1:0] data_in,
  output logic [W-1:0]  rem_out
);
  localparam int unsigned PAD = W - DW;

  logic [W-1:0] chain [0:DW];

  assign chain[0] = rem_in ^ {{PAD{1'b0}}, data_in};

  for (genvar g = 0; g < DW; g++) begin : g_step
    crc32_bit_step #(.W(W), .POLY(POLY)) u_step (
      .rem_in (chain[g]),
      .rem_out(chain[g+1])
    );
  end

  assign rem_out = chain[DW];
endmodule

// File: rtl/crc32_remainder.sv
// Running remainder register with same-cycle preset on restart.
module crc32_remainder #(
  parameter int unsigned  W      = crc32_pkg::CRC_WIDTH,
  parameter logic [W-1:0] PRESET = crc32_pkg::ALL_ONES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  input  logic         restart,
  input  logic [W-1:0] next_rem,
  output logic [W-1:0] seed
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= PRESET;
    end else if (advance) begin
      rem_q <= next_rem;
    end
  end

  assign seed = restart ? PRESET : rem_q;
endmodule

// File: rtl/crc32_result.sv
// Finalizes the remainder, holds the CRC and produces the registered verdict.
module crc32_result #(
  parameter int unsigned  W      = crc32_pkg::CRC_WIDTH,
  parameter logic [W-1:0] XOROUT = crc32_pkg::ALL_ONES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] final_rem,
  input  logic         chk_en,
  input  logic [W-1:0] chk_value,
  output logic [W-1:0] crc_out,
  output logic         done,
  output logic         pass,
  output logic         fail
);
  import crc32_pkg::verdict_t;

  logic [W-1:0] finished;
  logic         match;
  logic [W-1:0] crc_q;
  verdict_t     verdict_q;

  assign finished = final_rem ^ XOROUT;
  assign match    = (finished == chk_value);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q     <= '0;
      verdict_q <= '0;
    end else begin
      verdict_q.done <= fire;
      verdict_q.pass <= fire & chk_en & match;
      verdict_q.fail <= fire & chk_en & ~match;
      if (fire) begin
        crc_q <= finished;
      end
    end
  end

  assign crc_out = crc_q;
  assign done    = verdict_q.done;
  assign pass    = verdict_q.pass;
  assign fail    = verdict_q.fail;
endmodule

// File: rtl/crc32_stream_engine.sv
module crc32_stream_engine #(
  parameter int unsigned      CRC_W  = crc32_pkg::CRC_WIDTH,
  parameter int unsigned      DATA_W = crc32_pkg::BYTE_WIDTH,
  parameter logic [CRC_W-1:0] POLY   = crc32_pkg::REFL_POLY,
  parameter logic [CRC_W-1:0] PRESET = crc32_pkg::ALL_ONES,
  parameter logic [CRC_W-1:0] XOROUT = crc32_pkg::ALL_ONES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              chk_en,
  input  logic [CRC_W-1:0]  chk_value,
  output logic [CRC_W-1:0]  crc_out,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  logic             restart;
  logic             fire;
  logic [CRC_W-1:0] seed;
  logic [CRC_W-1:0] next_rem;

  // Strobes only count on valid beats (R11)
  assign restart = in_valid & in_sop;
  assign fire    = in_valid & in_eop;

  crc32_remainder #(.W(CRC_W), .PRESET(PRESET)) u_rem (
    .clk     (clk),
    .rst     (rst),
    .advance (in_valid),
    .restart (restart),
    .next_rem(next_rem),
    .seed    (seed)
  );

  crc32_byte_unroll #(.W(CRC_W), .DW(DATA_W), .POLY(POLY)) u_unroll (
    .rem_in (seed),
    .data_in(in_byte),
    .rem_out(next_rem)
  );

  crc32_result #(.W(CRC_W), .XOROUT(XOROUT)) u_res (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .final_rem(next_rem),
    .chk_en   (chk_en),
    .chk_value(chk_value),
    .crc_out  (crc_out),
    .done     (done),
    .pass     (pass),
    .fail     (fail)
  );
endmodule

// File: rtl/crc32_stream_checker.sv
module crc32_stream_checker #(
  parameter int unsigned CRC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_eop,
  input logic             chk_en,
  input logic [CRC_W-1:0] crc_out,
  input logic             done,
  input logic             pass,
  input logic             fail
);
  // R5: an end beat is followed by a done pulse
  p_done_follows_end_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop) |=> done);

  // R5 / R11: no done without a valid end beat
  p_no_stray_done_r5: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_eop) |=> !done);

  // R6: the CRC only moves when a new result is presented
  p_result_held_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(crc_out));

  // R7: verdict flags are exclusive
  p_verdict_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R7: verdict only alongside done
  p_verdict_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    (pass || fail) |-> done);

  // R7: check disabled on the end beat keeps both flags low
  p_check_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop && !chk_en) |=> (!pass && !fail));
endmodule

bind crc32_stream_engine crc32_stream_checker #(.CRC_W(CRC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_eop  (in_eop),
  .chk_en  (chk_en),
  .crc_out (crc_out),
  .done    (done),
  .pass    (pass),
  .fail    (fail)
);

// File: tb/sim_crc32_stream_engine.sv
`timescale 1ns/1ps
module sim_crc32_stream_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        chk_en = 1'b0;
  logic [31:0] chk_value = 32'h0;
  logic [31:0] crc_out;
  logic        done, pass, fail;

  always #10 clk = ~clk;

  crc32_stream_engine u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_byte(in_byte), .chk_en(chk_en),
    .chk_value(chk_value), .crc_out(crc_out), .done(done),
    .pass(pass), .fail(fail)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_acc = 32'hFFFFFFFF;
  logic [31:0] m_crc = 32'h0;
  logic        m_done = 0, m_pass = 0, m_fail = 0;

  logic [7:0]  msg_q[$];

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (((r[0]) ^ b[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_msg();
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    foreach (msg_q[i]) r = ref_byte(r, msg_q[i]);
    return ~r;
  endfunction

  task automatic check1(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    n_cmp++;
    if (crc_out !== m_crc || done !== m_done || pass !== m_pass || fail !== m_fail) begin
      n_bad++;
      $display("FAIL %s: got crc=%h d=%b p=%b f=%b expected crc=%h d=%b p=%b f=%b",
               tag, crc_out, done, pass, fail, m_crc, m_done, m_pass, m_fail);
    end
  endtask

  // one clock: drive at negedge, advance model, sample at next negedge
  task automatic beat(input string tag, input logic v, input logic s, input logic e,
                      input logic [7:0] b, input logic ck, input logic [31:0] cv);
    in_valid = v; in_sop = s; in_eop = e; in_byte = b; chk_en = ck; chk_value = cv;
    m_done = 0; m_pass = 0; m_fail = 0;
    if (v) begin
      if (s) m_acc = 32'hFFFFFFFF;
      m_acc = ref_byte(m_acc, b);
      if (e) begin
        m_crc  = ~m_acc;
        m_done = 1;
        m_pass = ck && (m_crc == cv);
        m_fail = ck && (m_crc != cv);
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic send_msg(input string tag, input logic ck, input logic [31:0] cv, input int gap);
    int n;
    n = msg_q.size();
    for (int i = 0; i < n; i++) begin
      beat(tag, 1'b1, i == 0, i == n - 1, msg_q[i], ck, cv);
      if (i != n - 1) begin
        for (int g = 0; g < gap; g++)
          beat("R11", 1'b0, 1'b1, 1'b1, 8'hA5, ck, cv);
      end
    end
  endtask

  task automatic load_digits();
    msg_q = {};
    for (int i = 0; i < 9; i++) msg_q.push_back(8'h31 + 8'(i));
  endtask

  initial begin
    logic [31:0] good;
    logic [127:0] flat;
    logic [127:0] pat;
    @(negedge clk);
    in_valid = 1; in_sop = 1; in_eop = 1; in_byte = 8'h55; chk_en = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    beat("R1", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
    check1("R1 crc_out after reset", crc_out, 32'h0);
    check1("R1 done after reset", {31'b0, done}, 32'h0);

    // R2 / R7 known vector, matching expected value
    load_digits();
    send_msg("R2", 1'b1, 32'hCBF43926, 0);
    check1("R2 known vector", crc_out, 32'hCBF43926);
    check1("R7 pass on match", {30'b0, pass, fail}, 32'h2);
    beat("R5", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
    check1("R5 done single cycle", {31'b0, done}, 32'h0);

    // R3 / R11 gaps with stray strobes
    send_msg("R3", 1'b1, 32'hCBF43926, 2);
    check1("R3 gaps do not change result", crc_out, 32'hCBF43926);

    // R6 hold across idle
    for (int i = 0; i < 4; i++) beat("R6", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
    check1("R6 result held", crc_out, 32'hCBF43926);

    // R7 mismatch and disabled check
    send_msg("R7", 1'b1, 32'hCBF43927, 0);
    check1("R7 fail on mismatch", {30'b0, pass, fail}, 32'h1);
    send_msg("R7", 1'b0, 32'hCBF43926, 1);
    check1("R7 check off quiet", {30'b0, pass, fail}, 32'h0);

    // R4 abandoned partial message
    beat("R4", 1'b1, 1'b1, 1'b0, 8'hDE, 1'b0, 32'h0);
    beat("R4", 1'b1, 1'b0, 1'b0, 8'hAD, 1'b0, 32'h0);
    load_digits();
    send_msg("R4", 1'b1, 32'hCBF43926, 0);
    check1("R4 restart discards partial", crc_out, 32'hCBF43926);

    // R10 one-byte messages, R5 back-to-back end beats
    beat("R10", 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 32'h0);
    check1("R10 single zero byte", crc_out, 32'hD202EF8D);
    beat("R5", 1'b1, 1'b1, 1'b1, 8'h61, 1'b0, 32'h0);
    check1("R5 back-to-back done", {31'b0, done}, 32'h1);

    // R8 every single-bit flip of a 16-byte message
    msg_q = {};
    for (int i = 0; i < 16; i++) msg_q.push_back(8'(i * 37 + 5));
    good = ref_msg();
    for (int i = 0; i < 16; i++) flat[i*8 +: 8] = msg_q[i];
    for (int p = 0; p < 128; p++) begin
      logic [127:0] bad;
      bad = flat;
      bad[p] = ~bad[p];
      for (int i = 0; i < 16; i++) msg_q[i] = bad[i*8 +: 8];
      send_msg("R8", 1'b1, good, 0);
      check1("R8 single-bit error flagged", {31'b0, fail}, 32'h1);
    end

    // R9 bursts of length 1..32 at several offsets
    for (int len = 1; len <= 32; len++) begin
      for (int k = 0; k < 3; k++) begin
        int off;
        logic [31:0] mask, bits;
        off  = (k == 0) ? 0 : ((k == 1) ? 37 : 96);
        mask = (len == 32) ? 32'hFFFFFFFF : ((32'h1 << len) - 1);
        bits = ($urandom | 32'h1 | (32'h1 << (len - 1))) & mask;
        pat  = {96'b0, bits} << off;
        pat  = flat ^ pat;
        for (int i = 0; i < 16; i++) msg_q[i] = pat[i*8 +: 8];
        send_msg("R9", 1'b1, good, 0);
        check1("R9 burst error flagged", {31'b0, fail}, 32'h1);
      end
    end

    beat("R5", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 32'h0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule